// File: doc/BRIEF.md
# I2C Target Sequential Memory Reader

This block is an I2C bus target with one fixed 7-bit device address, 0x21. It lets a bus controller read a byte-addressed memory through an internal 17-bit pointer. The controller sets the pointer with a write transaction that carries three bytes. It then reads consecutive bytes: the block sends the byte at the pointer and moves the pointer forward after each byte it sends. The pointer keeps its value between transactions, so one read picks up where the previous one stopped.

The block samples SCL and SDA with the system clock, which must be much faster than the bus. SDA is open drain, so the block only ever pulls it low, through an output-enable. The memory sits behind a synchronous read port. The block raises a one-cycle read strobe with the address, and the data arrives on the next cycle.

Top module: `i2c_seq_reader`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), no memory read is pending, and the pointer is 0, so the first read returns the byte at address 0.
- R2: The block ACKs an address byte whose upper 7 bits equal 0x21 (0x42 selects a write, 0x43 a read, with the direction in bit 0). It does not ACK any other address, and it then leaves the bus alone until the next START or STOP.
- R3: The block drives SDA only low, through `sda_oe_o`. It changes `sda_oe_o` only while SCL is low.
- R4: In a write, the block ACKs three data bytes, each sent MSB first. When the upper 7 bits of the first byte are zero, the low 17 bits of the 24-bit value (first byte most significant) become the pointer.
- R5: If the first written byte has any of its upper 7 bits set, the three bytes are still ACKed, but the pointer stays unchanged.
- R6: A write that ends with fewer than three data bytes, by STOP or by repeated START, leaves the pointer unchanged.
- R7: The block NACKs the fourth and every later data byte of a write.
- R8: In a read, the block sends the byte at the pointer MSB first. It keeps sending further bytes while the controller ACKs. After a NACK it releases SDA and sends nothing more.
- R9: The pointer goes up by one after each byte the block sends, including the byte that is NACKed. It keeps its value across transactions.
- R10: The pointer wraps from 0x1FFFF to 0.
- R11: A STOP or a repeated START releases SDA at any point and sends the block back to waiting for an address byte.
- R12: Each read from memory is a one-cycle `mem_rd_o` pulse with `mem_addr_o`. The block takes the data from `mem_data_i` on the next cycle. There is exactly one read per byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | 17 | Memory byte address (current pointer) |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |

## Verification
The bench builds the block with its default parameters: the 0x21 address, a 17-bit pointer and a two-stage input synchronizer. With a 17-bit pointer, writing 0x01 0xFF 0xFF sets the pointer to its last address, so a three-byte read then shows the wrap to zero directly. The 24-bit write value leaves seven padding bits, which lets the bench cover the rejected-pointer case. Random pointer values and read lengths are mixed with directed cases for short writes, overlong writes, a wrong device address and a repeated START in the middle of a write.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } rd_state_e;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] scl_sr, sda_sr;
  logic scl_now, scl_prv, sda_now, sda_prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SR_W-2:0], scl_i};
      sda_sr <= {sda_sr[SR_W-2:0], sda_i};
    end
  end

  assign scl_now = scl_sr[SYNC_STAGES-1];
  assign scl_prv = scl_sr[SYNC_STAGES];
  assign sda_now = sda_sr[SYNC_STAGES-1];
  assign sda_prv = sda_sr[SYNC_STAGES];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prv;
  assign scl_fall_o = ~scl_now & scl_prv;
  // SDA edge while SCL stays high
  assign start_o    = scl_now & scl_prv & sda_prv & ~sda_now;
  assign stop_o     = scl_now & scl_prv & ~sda_prv & sda_now;
endmodule

// File: rtl/i2c_rd_ptr.sv
module i2c_rd_ptr #(
  parameter int PTR_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h21,
  parameter int         PTR_W    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       mem_data_i,
  output logic             sda_oe_o,
  output logic             rd_req_o,
  output logic             ptr_inc_o,
  output logic             ptr_load_o,
  output logic [PTR_W-1:0] ptr_val_o,
  output rd_state_e        state_o
);
  localparam int ADDR_BYTES = (PTR_W + 7) / 8;
  localparam int WB_W       = ADDR_BYTES * 8;
  localparam int PAD_W      = WB_W - PTR_W;
  localparam int WC_W       = $clog2(ADDR_BYTES + 1);

  rd_state_e       state;
  logic [3:0]      cnt;
  logic [7:0]      sh_rx, sh_tx;
  logic [WB_W-1:0] wbuf;
  logic [WC_W-1:0] wcnt;
  logic            rw, ackd, rd_pend, pad_ok;

  generate
    if (PAD_W > 0) begin : g_pad
      assign pad_ok = (wbuf[WB_W-1:PTR_W] == '0);
    end else begin : g_nopad
      assign pad_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh_rx      <= '0;
      sh_tx      <= '0;
      wbuf       <= '0;
      wcnt       <= '0;
      rw         <= 1'b0;
      ackd       <= 1'b0;
      rd_pend    <= 1'b0;
      sda_oe_o   <= 1'b0;
      rd_req_o   <= 1'b0;
      ptr_inc_o  <= 1'b0;
      ptr_load_o <= 1'b0;
    end else begin
      rd_req_o   <= 1'b0;
      ptr_inc_o  <= 1'b0;
      ptr_load_o <= 1'b0;
      rd_pend    <= rd_req_o;
      if (rd_pend) sh_tx <= mem_data_i;

      if (start_i) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_rx <= {sh_rx[6:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              if (sh_rx[7:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1;
                rw       <= sh_rx[0];
                rd_req_o <= sh_rx[0];
                wcnt     <= '0;
                wbuf     <= '0;
                state    <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rw) begin
                sda_oe_o <= ~sh_tx[7];
                sh_tx    <= {sh_tx[6:0], 1'b0};
                cnt      <= 4'd1;
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_WDATA;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise_i) begin
              sh_rx <= {sh_rx[6:0], sda_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (wcnt < WC_W'(ADDR_BYTES)) begin
                sda_oe_o <= 1'b1;
                wbuf     <= (wbuf << 8) | WB_W'(sh_rx);
                wcnt     <= wcnt + 1'b1;
                state    <= ST_WACK;
              end else begin
                state <= ST_SKIP;  // surplus byte: NACK
              end
            end
          end
          ST_WACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_WDATA;
              if (wcnt == WC_W'(ADDR_BYTES) && pad_ok) ptr_load_o <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (cnt == 4'd8) begin
                sda_oe_o  <= 1'b0;
                ptr_inc_o <= 1'b1;
                state     <= ST_RACK;
              end else begin
                sda_oe_o <= ~sh_tx[7];
                sh_tx    <= {sh_tx[6:0], 1'b0};
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              ackd     <= ~sda_i;
              rd_req_o <= ~sda_i;
            end else if (scl_fall_i) begin
              if (ackd) begin
                sda_oe_o <= ~sh_tx[7];
                sh_tx    <= {sh_tx[6:0], 1'b0};
                cnt      <= 4'd1;
                state    <= ST_RDATA;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_val_o = wbuf[PTR_W-1:0];
  assign state_o   = state;
endmodule

// File: rtl/i2c_seq_reader.sv
module i2c_seq_reader
  import i2c_rd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h21,
  parameter int         PTR_W       = 17,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             mem_rd_o,
  output logic [PTR_W-1:0] mem_addr_o,
  input  logic [7:0]       mem_data_i
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             ptr_inc, ptr_load;
  logic [PTR_W-1:0] ptr_val;
  rd_state_e        fsm_state;

  i2c_rd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_rd_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .mem_data_i (mem_data_i),
    .sda_oe_o   (sda_oe_o),
    .rd_req_o   (mem_rd_o),
    .ptr_inc_o  (ptr_inc),
    .ptr_load_o (ptr_load),
    .ptr_val_o  (ptr_val),
    .state_o    (fsm_state)
  );

  i2c_rd_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_val),
    .inc_i      (ptr_inc),
    .ptr_o      (mem_addr_o)
  );
endmodule

// File: rtl/i2c_seq_reader_chk.sv
module i2c_seq_reader_chk
  import i2c_rd_pkg::*;
#(
  parameter int PTR_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             mem_rd_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic             ptr_inc,
  input logic             ptr_load,
  input logic             start_det,
  input logic             stop_det,
  input rd_state_e        fsm_state
);
  p_oe_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_quiet_unselected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_IDLE || fsm_state == ST_SKIP) |-> !sda_oe_o);

  p_ptr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_inc && !ptr_load) |=> (mem_addr_o == PTR_W'($past(mem_addr_o) + 1'b1)));

  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_inc && !ptr_load) |=> $stable(mem_addr_o));

  p_rd_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_cond_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det || stop_det) |=> !sda_oe_o);
endmodule

bind i2c_seq_reader i2c_seq_reader_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .ptr_inc    (ptr_inc),
  .ptr_load   (ptr_load),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .fsm_state  (fsm_state)
);

// File: tb/i2c_seq_reader_test.sv
module i2c_seq_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;   // system clocks per quarter bit
  localparam int PW         = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl = 1'b1;
  logic          ctl_low = 1'b0;
  logic          sda_oe, mem_rd;
  logic [PW-1:0] mem_addr;
  logic [7:0]    mem_q = 8'h00;
  wire           sda_line = ~(ctl_low | sda_oe);

  int vec_cnt = 0;
  int err_cnt = 0;
  int rd_pulses = 0;
  int r3_viol = 0;
  logic [PW-1:0] exp_ptr = '0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_seq_reader uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_q)
  );

  function automatic logic [7:0] mem_f(input logic [PW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd13 ^ (32'(a) >> 7) ^ 32'h5A;
    return t[7:0];
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_q <= mem_f(mem_addr);

  always @(posedge clk) begin
    if (mem_rd) rd_pulses <= rd_pulses + 1;
    if (rst_n && sda_oe !== prev_oe && scl) r3_viol <= r3_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; wq(1); ctl_low = ~b; wq(1);
    scl = 1'b1; wq(2); scl = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    scl = 1'b0; wq(1); ctl_low = 1'b0; wq(1);
    scl = 1'b1; wq(1); b = sda_line; wq(1); scl = 1'b0;
  endtask

  task automatic i2c_start();
    if (!scl) begin
      ctl_low = 1'b0; wq(1); scl = 1'b1; wq(2);
    end
    ctl_low = 1'b1; wq(2); scl = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    scl = 1'b0; wq(1); ctl_low = 1'b1; wq(1);
    scl = 1'b1; wq(2); ctl_low = 1'b0; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    read_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin read_bit(v); b[i] = v; end
    send_bit(~ack);
  endtask

  // read n bytes, compare with the model, advance expected pointer
  task automatic read_seq(input int n, input string req);
    logic a;
    logic [7:0] d;
    int p0;
    p0 = rd_pulses;
    i2c_start();
    send_byte(8'h43, a);
    chk(a, "R2 read address ack", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == mem_f(exp_ptr), req, int'(d), int'(mem_f(exp_ptr)));
      exp_ptr = exp_ptr + 1'b1;
    end
    i2c_stop();
    chk(rd_pulses - p0 == n, "R12 one read strobe per byte", rd_pulses - p0, n);
    chk(sda_oe == 1'b0, "R8 SDA released after NACK", int'(sda_oe), 0);
  endtask

  task automatic write_seq(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input string req);
    logic a;
    i2c_start();
    send_byte(8'h42, a);
    chk(a, "R2 write address ack", int'(a), 1);
    send_byte(b0, a); chk(a, req, int'(a), 1);
    send_byte(b1, a); chk(a, req, int'(a), 1);
    send_byte(b2, a); chk(a, req, int'(a), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'h51a7));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 SDA released at reset", int'(sda_oe), 0);
    chk(mem_rd == 1'b0, "R1 no read at reset", int'(mem_rd), 0);
    chk(mem_addr == '0, "R1 pointer zero", int'(mem_addr), 0);

    read_seq(4, "R1 R8 read from reset pointer");
    read_seq(2, "R9 read continues across transactions");

    // wrong device address: NACK, following byte ignored
    i2c_start();
    send_byte(8'hA0, a);
    chk(!a, "R2 foreign address NACK", int'(a), 0);
    send_byte(8'h00, a);
    chk(!a, "R2 bus ignored after foreign address", int'(a), 0);
    i2c_stop();
    read_seq(1, "R2 pointer untouched by foreign traffic");

    write_seq(8'h00, 8'h01, 8'h23, "R4 address byte ack");
    i2c_stop();
    exp_ptr = 17'h00123;
    read_seq(3, "R4 read at loaded pointer");

    write_seq(8'h02, 8'h00, 8'h10, "R5 padded byte still ack");
    i2c_stop();
    read_seq(1, "R5 pointer kept on nonzero pad");

    i2c_start();
    send_byte(8'h42, a);
    send_byte(8'h00, a);
    send_byte(8'h55, a);
    i2c_stop();
    read_seq(1, "R6 short write keeps pointer");

    write_seq(8'h01, 8'hFF, 8'hFF, "R4 ack");
    send_byte(8'h00, a);
    chk(!a, "R7 fourth byte NACK", int'(a), 0);
    i2c_stop();
    exp_ptr = 17'h1FFFF;
    read_seq(3, "R10 wrap to zero");
    chk(exp_ptr == 17'd2, "R10 model wrap", int'(exp_ptr), 2);

    // one-byte write then repeated START into a read
    i2c_start();
    send_byte(8'h42, a);
    send_byte(8'h00, a);
    i2c_start();
    send_byte(8'h43, a);
    chk(a, "R11 repeated START readdresses", int'(a), 1);
    recv_byte(1'b1, d);
    chk(d == mem_f(exp_ptr), "R11 R6 read after restart", int'(d), int'(mem_f(exp_ptr)));
    exp_ptr = exp_ptr + 1'b1;
    recv_byte(1'b0, d);
    chk(d == mem_f(exp_ptr), "R11 second byte", int'(d), int'(mem_f(exp_ptr)));
    exp_ptr = exp_ptr + 1'b1;
    i2c_stop();
    chk(sda_oe == 1'b0, "R11 SDA released after STOP", int'(sda_oe), 0);

    for (int it = 0; it < 12; it++) begin
      logic [PW-1:0] p;
      int n;
      p = PW'($urandom);
      n = 1 + int'($urandom % 5);
      write_seq({7'd0, p[16]}, p[15:8], p[7:0], "R4 random ack");
      i2c_stop();
      exp_ptr = p;
      read_seq(n, "R8 R9 random sequential read");
    end

    chk(r3_viol == 0, "R3 drive changes only with SCL low", r3_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule